// File: doc/BRIEF.md
# Hierarchical Read-to-Clear SMI Status

This block gathers several power-management event sources into one 8-bit second-level status byte. It also keeps a one-bit top-level summary that drives an active-high system-management interrupt request. Asynchronous level inputs pass through a two-flop synchronizer. The block latches only their rising transitions: thermal alarm, power-up request, RTC interrupt and codec serial data. The timer MSB is already synchronous, and every toggle of it counts as an event. Each source has its own qualifier: a dedicated enable, the suspend state, or the PME-to-SMI routing control, where a value of 0 routes events to SMI.

Software sees the byte on `status_rd`, which is combinational. A one-cycle `rd_clr` strobe marks a destructive read. At the next edge it clears every latched bit and drops the summary, unless something is still pending. A `mirror_rd` strobe reads the same byte on `mirror_data` and has no effect on any state. Bit 7 is not latched. It passes through a pending flag from a deeper GPIO status level, so only that deeper level can clear it.

The summary is a two-state machine. In ST_QUIET nothing is pending. The transition "raise" goes from ST_QUIET to ST_ALERT when any event is latched or bit 7 is high. The transition "release" goes from ST_ALERT back to ST_QUIET on a clearing read in a cycle with no new event and bit 7 low. In every other case ST_ALERT holds.

Top module: `pm_smi_status`

## Requirements
- R1: After reset, `status_rd` reads 8'h00 and `top_sum` and `smi_req` are 0.
- R2: With `therm_en` = 1, a falling edge of `therm_n` (alarm assertion) sets bit 6. The bit stays set until a clearing read. With `therm_en` = 0 the alarm sets nothing.
- R3: With `codec_en` = 1, a rising edge of `codec_sdin` sets bit 2. A falling edge, or any edge with `codec_en` = 0, sets nothing.
- R4: With `tmr_en` = 1, each toggle of `tmr_msb` in either direction sets bit 0 at the first clock edge after the change.
- R5: A rising edge of `rtc_irq` sets bit 1 only when `suspend_st` = 1 and `pme_route_ctl` = 0.
- R6: A rising edge of `pwr_req` sets bit 3 only when `pme_route_ctl` = 0. Bit 7 reads `gpio_pend` while `pme_route_ctl` = 0 and reads 0 otherwise. A clearing read does not clear bit 7.
- R7: A one-cycle `rd_clr` pulse clears bits 6, 3, 2, 1 and 0 at the next edge. If no event and no bit 7 is pending, it also drops `top_sum` and `smi_req`.
- R8: `mirror_data` always equals `status_rd`, and a `mirror_rd` pulse changes no status bit and no summary.
- R9: An event that lands in the same cycle as `rd_clr` stays latched after the read.
- R10: Bits 5 and 4 always read 0.
- R11: `smi_req` and `top_sum` rise at the edge that latches any event, or one edge after bit 7 goes high. They stay high until a clearing read leaves nothing pending.
- R12: Each level input passes through two synchronizer flops. A change at the input appears in the status byte at the third clock edge after the change, and not before. Only rising transitions of the active level latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| suspend_st | input | 1 | System is in the suspend state |
| pme_route_ctl | input | 1 | PME-to-SMI routing control, 0 routes events to SMI |
| therm_n | input | 1 | Thermal alarm, active low, asynchronous |
| therm_en | input | 1 | Thermal event enable |
| pwr_req | input | 1 | Power-up request level, asynchronous |
| rtc_irq | input | 1 | RTC interrupt level, asynchronous |
| codec_sdin | input | 1 | Codec serial data input, asynchronous |
| codec_en | input | 1 | Codec event enable |
| tmr_msb | input | 1 | Timer counter MSB, synchronous |
| tmr_en | input | 1 | Timer toggle event enable |
| gpio_pend | input | 1 | Deeper-level GPIO status pending |
| rd_clr | input | 1 | Destructive read strobe |
| mirror_rd | input | 1 | Non-destructive mirror read strobe |
| status_rd | output | 8 | Second-level status byte |
| mirror_data | output | 8 | Mirror view of the status byte |
| top_sum | output | 1 | Top-level summary status bit |
| smi_req | output | 1 | SMI request, active high |

## Verification
The bench goes after four races:
- **A read in the same cycle as a timer toggle.** A design that clears before it merges the new event loses the interrupt.
- **A clearing read while the GPIO flag is still high.** A design that drops the summary releases SMI while work is still pending.
- **A mirror read.** A design that shares the clear path with the mirror wipes the status byte.
- **The exact cycle a synchronized input shows up.** An extra or a missing flop moves that cycle, and the per-cycle compare catches it.

Falling edges, held levels and disabled or wrongly routed sources are also driven. A design that latches on level or ignores a qualifier sets bits it must not set.

// File: rtl/pm_smi_pkg.sv
package pm_smi_pkg;
    localparam int STAT_W  = 8;
    localparam int LVL_W   = 4;
    localparam int B_TMR   = 0;
    localparam int B_RTC   = 1;
    localparam int B_CODEC = 2;
    localparam int B_PWR   = 3;
    localparam int B_THERM = 6;
    localparam int B_GPIO  = 7;
    // index of each level source inside the synchronized vector
    localparam int L_THERM = 0;
    localparam int L_PWR   = 1;
    localparam int L_RTC   = 2;
    localparam int L_CODEC = 3;

    typedef enum logic [0:0] {
        ST_QUIET = 1'b0,
        ST_ALERT = 1'b1
    } smi_state_t;
endpackage

// File: rtl/pm_smi_sync.sv
module pm_smi_sync #(
    parameter int W     = 4,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [W-1:0] stg [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d_in;
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_chain
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
        end
    end

    assign q_out = stg[DEPTH-1];
endmodule

// File: rtl/pm_smi_edge.sv
module pm_smi_edge #(
    parameter int W      = 1,
    parameter bit TOGGLE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] pulse
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    if (TOGGLE) begin : g_toggle
        assign pulse = lvl ^ prev_q;
    end else begin : g_rise
        assign pulse = lvl & ~prev_q;
    end
endmodule

// File: rtl/pm_smi_fsm.sv
module pm_smi_fsm
    import pm_smi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_ev,
    input  logic hold,
    input  logic rd_clr,
    output logic alert
);
    smi_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: if (any_ev || hold) state_d = ST_ALERT;               // raise
            ST_ALERT: if (rd_clr && !any_ev && !hold) state_d = ST_QUIET;   // release
            default:  state_d = ST_QUIET;
        endcase
    end

    always_comb begin
        alert = (state_q == ST_ALERT);
    end
endmodule

// File: rtl/pm_smi_status.sv
module pm_smi_status
    import pm_smi_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              suspend_st,
    input  logic              pme_route_ctl,
    input  logic              therm_n,
    input  logic              therm_en,
    input  logic              pwr_req,
    input  logic              rtc_irq,
    input  logic              codec_sdin,
    input  logic              codec_en,
    input  logic              tmr_msb,
    input  logic              tmr_en,
    input  logic              gpio_pend,
    input  logic              rd_clr,
    input  logic              mirror_rd,
    output logic [STAT_W-1:0] status_rd,
    output logic [STAT_W-1:0] mirror_data,
    output logic              top_sum,
    output logic              smi_req
);
    logic [LVL_W-1:0]  raw_lvl, sync_lvl, rise;
    logic              tgl;
    logic [STAT_W-1:0] ev, lat_q;
    logic              gpio_bit, alert;

    always_comb begin
        raw_lvl          = '0;
        raw_lvl[L_THERM] = ~therm_n;
        raw_lvl[L_PWR]   = pwr_req;
        raw_lvl[L_RTC]   = rtc_irq;
        raw_lvl[L_CODEC] = codec_sdin;
    end

    pm_smi_sync #(.W(LVL_W), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(raw_lvl), .q_out(sync_lvl)
    );

    pm_smi_edge #(.W(LVL_W), .TOGGLE(1'b0)) u_rise (
        .clk(clk), .rst_n(rst_n), .lvl(sync_lvl), .pulse(rise)
    );

    pm_smi_edge #(.W(1), .TOGGLE(1'b1)) u_tgl (
        .clk(clk), .rst_n(rst_n), .lvl(tmr_msb), .pulse(tgl)
    );

    always_comb begin
        ev          = '0;
        ev[B_THERM] = rise[L_THERM] & therm_en;
        ev[B_PWR]   = rise[L_PWR] & ~pme_route_ctl;
        ev[B_RTC]   = rise[L_RTC] & suspend_st & ~pme_route_ctl;
        ev[B_CODEC] = rise[L_CODEC] & codec_en;
        ev[B_TMR]   = tgl & tmr_en;
    end

    // read clears what it returned; same-cycle events survive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= (rd_clr ? '0 : lat_q) | ev;
    end

    assign gpio_bit = gpio_pend & ~pme_route_ctl;

    always_comb begin
        status_rd         = lat_q;
        status_rd[B_GPIO] = gpio_bit;
        status_rd[5:4]    = 2'b00;
    end
    assign mirror_data = status_rd;

    pm_smi_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .any_ev(|ev), .hold(gpio_bit),
        .rd_clr(rd_clr), .alert(alert)
    );

    assign top_sum = alert;
    assign smi_req = alert;

    p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd[5:4] == 2'b00);

    p_smi_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q != '0) |-> smi_req);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && ev == '0) |=> (lat_q == '0));

    p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> ((lat_q & $past(ev)) == $past(ev)));

    p_gpio_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && gpio_pend && !pme_route_ctl) |=> smi_req);

    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr && lat_q[B_THERM]) |=> lat_q[B_THERM]);

    p_rtc_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!suspend_st && !lat_q[B_RTC]) |=> !lat_q[B_RTC]);

    p_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mirror_rd && !rd_clr && ev == '0) |=> $stable(lat_q));
endmodule

// File: tb/sim_pm_smi_status.sv
module sim_pm_smi_status;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic suspend_st = 0, pme_route_ctl = 0, therm_n = 1, therm_en = 0;
    logic pwr_req = 0, rtc_irq = 0, codec_sdin = 0, codec_en = 0;
    logic tmr_msb = 0, tmr_en = 0, gpio_pend = 0, rd_clr = 0, mirror_rd = 0;
    logic [7:0] status_rd, mirror_data;
    logic top_sum, smi_req;

    int checks = 0, errors = 0;
    string phase = "R1 reset";

    always #10 clk = ~clk;

    pm_smi_status u0 (.*);

    // behavioural reference: histories of sampled levels
    int th_h[$], pu_h[$], rt_h[$], cd_h[$];
    int m_lat = 0, m_smi = 0, m_tprev = 0;

    function automatic int m_status();
        int s;
        s = m_lat;
        if (gpio_pend && !pme_route_ctl) s = s + 128;
        return s;
    endfunction

    initial begin
        th_h = '{0,0,0}; pu_h = '{0,0,0}; rt_h = '{0,0,0}; cd_h = '{0,0,0};
    end

    always @(posedge clk) begin
        int evm;
        int b7;
        if (!rst_n) begin
            th_h = '{0,0,0}; pu_h = '{0,0,0}; rt_h = '{0,0,0}; cd_h = '{0,0,0};
            m_lat = 0; m_smi = 0; m_tprev = 0;
        end else begin
            evm = 0;
            if (th_h[1] && !th_h[0] && therm_en) evm += 64;
            if (pu_h[1] && !pu_h[0] && !pme_route_ctl) evm += 8;
            if (cd_h[1] && !cd_h[0] && codec_en) evm += 4;
            if (rt_h[1] && !rt_h[0] && suspend_st && !pme_route_ctl) evm += 2;
            if ((int'(tmr_msb) != m_tprev) && tmr_en) evm += 1;
            b7 = (gpio_pend && !pme_route_ctl) ? 1 : 0;
            if (rd_clr) begin
                m_lat = evm;
                m_smi = (evm != 0 || b7 != 0) ? 1 : 0;
            end else begin
                m_lat = m_lat | evm;
                if (evm != 0 || b7 != 0) m_smi = 1;
            end
            m_tprev = tmr_msb;
            th_h.push_back(!therm_n); void'(th_h.pop_front());
            pu_h.push_back(pwr_req);  void'(pu_h.pop_front());
            rt_h.push_back(rtc_irq);  void'(rt_h.pop_front());
            cd_h.push_back(codec_sdin); void'(cd_h.pop_front());
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle compare against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            chk({phase, " status"}, status_rd, m_status());
            chk("R8 mirror equals status", mirror_data, status_rd);
            chk({phase, " smi"}, smi_req, m_smi);
            chk("R11 top_sum", top_sum, m_smi);
            chk("R10 reserved bits", status_rd[5:4], 0);
        end
    end

    task automatic step(int n);
        repeat (n) begin @(posedge clk); #5; end
    endtask

    task automatic clear_read();
        rd_clr = 1; step(1); rd_clr = 0; step(1);
    endtask

    initial begin
        step(3);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset status", status_rd, 0);
        chk("R1 reset smi", smi_req, 0);
        step(1);

        phase = "R2 thermal";
        therm_en = 1; therm_n = 0;
        step(2); @(negedge clk);
        chk("R12 not before third edge", status_rd[6], 0);
        step(1); @(negedge clk);
        chk("R2 thermal latched", status_rd[6], 1);
        chk("R11 smi raised", smi_req, 1);
        step(4); therm_n = 1; step(4); @(negedge clk);
        chk("R2 sticky", status_rd, 8'h40);

        phase = "R7 clear";
        clear_read(); @(negedge clk);
        chk("R7 cleared", status_rd, 0);
        chk("R7 smi dropped", smi_req, 0);
        phase = "R12 level held";
        therm_n = 0; step(6); therm_n = 1; step(4); @(negedge clk);
        chk("R12 single latch", status_rd, 8'h40);
        clear_read();
        therm_en = 0; therm_n = 0; step(5); therm_n = 1; step(4); @(negedge clk);
        chk("R2 disabled", status_rd, 0);

        phase = "R3 codec";
        codec_sdin = 1; step(5); codec_sdin = 0; step(5); @(negedge clk);
        chk("R3 disabled", status_rd, 0);
        codec_en = 1; codec_sdin = 1; step(5); @(negedge clk);
        chk("R3 rising", status_rd, 8'h04);
        clear_read(); codec_sdin = 0; step(5); @(negedge clk);
        chk("R3 falling ignored", status_rd, 0);

        phase = "R4 timer";
        tmr_en = 1; tmr_msb = 1; step(1); @(negedge clk);
        chk("R4 rise toggle", status_rd, 8'h01);
        clear_read(); tmr_msb = 0; step(1); @(negedge clk);
        chk("R4 fall toggle", status_rd, 8'h01);
        clear_read();

        phase = "R9 read race";
        tmr_msb = 1; rd_clr = 1; step(1); rd_clr = 0; @(negedge clk);
        chk("R9 kept", status_rd, 8'h01);
        chk("R9 smi kept", smi_req, 1);
        clear_read();

        phase = "R5 rtc";
        rtc_irq = 1; step(5); rtc_irq = 0; step(4); @(negedge clk);
        chk("R5 not suspended", status_rd, 0);
        suspend_st = 1; pme_route_ctl = 1; rtc_irq = 1; step(5); rtc_irq = 0; step(4);
        @(negedge clk);
        chk("R5 routed away", status_rd, 0);
        pme_route_ctl = 0; rtc_irq = 1; step(5); rtc_irq = 0; step(4); @(negedge clk);
        chk("R5 latched", status_rd, 8'h02);
        clear_read(); suspend_st = 0;

        phase = "R6 power-up";
        pme_route_ctl = 1; pwr_req = 1; step(5); pwr_req = 0; step(4); @(negedge clk);
        chk("R6 pwr routed away", status_rd, 0);
        pme_route_ctl = 0; pwr_req = 1; step(5); pwr_req = 0; step(4); @(negedge clk);
        chk("R6 pwr latched", status_rd, 8'h08);
        clear_read();

        phase = "R6 gpio";
        gpio_pend = 1; step(1); @(negedge clk);
        chk("R6 gpio bit", status_rd, 8'h80);
        clear_read(); @(negedge clk);
        chk("R6 gpio not cleared", status_rd, 8'h80);
        chk("R11 smi held by gpio", smi_req, 1);
        pme_route_ctl = 1; #1;
        chk("R6 gpio masked", status_rd, 0);
        pme_route_ctl = 0;
        gpio_pend = 0; step(2); @(negedge clk);
        chk("R11 smi sticky", smi_req, 1);
        clear_read(); @(negedge clk);
        chk("R11 released", smi_req, 0);

        phase = "R8 mirror";
        tmr_msb = 0; step(1);
        mirror_rd = 1; step(1); mirror_rd = 0; step(2); @(negedge clk);
        chk("R8 mirror no clear", status_rd, 8'h01);
        chk("R8 mirror smi held", smi_req, 1);
        chk("R8 mirror value", mirror_data, 8'h01);
        clear_read();
        step(3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule